// File: doc/BRIEF.md
# Ping-Pong DMA Buffer Status Tracker

This block keeps the status of a DMA channel that alternates between two memory buffers, called A and B, in each direction. For receive and for transmit it holds a next-buffer pointer and a busy flag. The pointer flips on the first data access to a buffer, not when that buffer completes. On the transmit side it also records which physical buffer is being drained at the moment.

The transmit side has an append mode, and only buffer A may hold appended data. A host command starts append mode. A terminate command marks the appended data for flushing. The datapath then reports when the flush is finished, and append mode ends there.

All state is shown on a 16-bit status word that the host can read. Host writes to this word have no effect. An append request that arrives while buffer A is being drained with normal data is dropped, and a sticky error output records that it was dropped.

Top module: `dbuf_status_tracker`

## Requirements
- R1: A synchronous reset, active high, clears every status bit and the error output to 0. This selects buffer A as next in both directions, with no buffer busy.
- R2: Status bit 0 is the receive next-buffer pointer, where 0 means A and 1 means B. Each receive first-write strobe inverts it. After the first write into A it reads 1.
- R3: Status bit 2 is the transmit next-buffer pointer, with the same 0 = A and 1 = B encoding. Each transmit first-read strobe inverts it. Status bit 4 takes the value the pointer had before the flip, so it shows the buffer now being drained.
- R4: Status bit 1 is the receive busy flag and status bit 3 is the transmit busy flag. A first-access strobe sets the flag of its direction. A done strobe clears it. When both strobes arrive in the same cycle, the flag stays set.
- R5: An append request sets status bit 5 (append active) when the transmit side is idle, or when it is busy on buffer B.
- R6: An append request that arrives while transmit is busy and bit 4 is 0 (buffer A) is ignored, and bit 5 does not change. The error output is then set, and it stays set until reset.
- R7: A terminate command sets status bit 6 (append reset pending) only while bit 5 is 1. At any other time it has no effect.
- R8: A flush-done indication that arrives while bit 6 is 1 clears both bit 6 and bit 5. At any other time it has no effect.
- R9: Host writes do not change the status word, whatever data they carry. Status bits 15 to 7 always read 0.
- R10: Every change of status is visible on the status word in the clock cycle after the strobe that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_first_wr | input | 1 | First write of receive data into a buffer |
| rx_done | input | 1 | Receive buffer completed |
| tx_first_rd | input | 1 | First read of transmit data from a buffer |
| tx_done | input | 1 | Transmit buffer completed |
| append_req | input | 1 | Host command: start append mode on buffer A |
| term_append | input | 1 | Host command: terminate the append buffer |
| flush_done | input | 1 | Remaining append data has been flushed |
| host_wr | input | 1 | Host write strobe to the status word (ignored) |
| host_wdata | input | 16 | Host write data (ignored) |
| status_o | output | 16 | Status word |
| append_err_o | output | 1 | Sticky flag: an append request was dropped |

## Verification
The bound checker tests on every cycle how the strobes map to the status word. It checks that the pointers flip, that bit 4 follows the pointer value from before the flip, and that the busy flags set and clear. It also checks that append reset pending never appears without append active, that the error flag stays set once raised, and that a lone host write leaves the status unchanged. The bench's scenarios are needed to show full sequences: several buffer cycles in a row, the whole append, terminate and flush round trip, and a request dropped while busy on A compared with one accepted while busy on B. They also show that terminate and flush-done do nothing when they arrive out of order.

// File: rtl/dbuf_status_pkg.sv
package dbuf_status_pkg;
  localparam int STATUS_W   = 16;
  localparam int NUM_DIR    = 2;
  localparam int DIR_RX     = 0;
  localparam int DIR_TX     = 1;
  localparam int B_RX_NEXT  = 0;
  localparam int B_RX_BUSY  = 1;
  localparam int B_TX_NEXT  = 2;
  localparam int B_TX_BUSY  = 3;
  localparam int B_TX_CUR   = 4;
  localparam int B_APP_ACT  = 5;
  localparam int B_APP_RST  = 6;

  typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_sel_e;

  typedef struct packed {
    logic     app_rst;
    logic     app_act;
    buf_sel_e tx_cur;
    logic     tx_busy;
    buf_sel_e tx_next;
    logic     rx_busy;
    buf_sel_e rx_next;
  } status_t;

  function automatic buf_sel_e other_buf(input buf_sel_e b);
    return (b == BUF_A) ? BUF_B : BUF_A;
  endfunction

  function automatic logic busy_next(input logic cur, input logic first_acc,
                                     input logic done);
    return first_acc | (cur & ~done);
  endfunction

  function automatic logic [STATUS_W-1:0] pack_status(input status_t s);
    logic [STATUS_W-1:0] w;
    w            = '0;
    w[B_RX_NEXT] = s.rx_next;
    w[B_RX_BUSY] = s.rx_busy;
    w[B_TX_NEXT] = s.tx_next;
    w[B_TX_BUSY] = s.tx_busy;
    w[B_TX_CUR]  = s.tx_cur;
    w[B_APP_ACT] = s.app_act;
    w[B_APP_RST] = s.app_rst;
    return w;
  endfunction
endpackage

// File: rtl/dbuf_dir_track.sv
module dbuf_dir_track
  import dbuf_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     first_acc,
  input  logic     done,
  output buf_sel_e next_buf,
  output buf_sel_e cur_buf,
  output logic     busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      next_buf <= BUF_A;
      cur_buf  <= BUF_A;
      busy     <= 1'b0;
    end else begin
      busy <= busy_next(busy, first_acc, done);
      if (first_acc) begin
        cur_buf  <= next_buf;
        next_buf <= other_buf(next_buf);
      end
    end
  end
endmodule

// File: rtl/dbuf_append_ctl.sv
module dbuf_append_ctl
  import dbuf_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     append_req,
  input  logic     term_append,
  input  logic     flush_done,
  input  logic     tx_busy,
  input  buf_sel_e tx_cur,
  output logic     app_act,
  output logic     app_rst,
  output logic     app_err,
  output logic     req_dropped,
  output logic     term_taken,
  output logic     flush_taken
);
  logic a_in_use;
  assign a_in_use    = tx_busy & (tx_cur == BUF_A);
  assign req_dropped = append_req & a_in_use;
  assign term_taken  = term_append & app_act & ~app_rst;
  assign flush_taken = flush_done & app_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      app_act <= 1'b0;
      app_rst <= 1'b0;
      app_err <= 1'b0;
    end else begin
      if (req_dropped) app_err <= 1'b1;
      if (flush_taken) begin
        app_act <= 1'b0;
        app_rst <= 1'b0;
      end else begin
        if (append_req & ~a_in_use) app_act <= 1'b1;
        if (term_taken) app_rst <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbuf_status_tracker.sv
module dbuf_status_tracker
  import dbuf_status_pkg::*;
#(
  parameter int SW = STATUS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_first_wr,
  input  logic          rx_done,
  input  logic          tx_first_rd,
  input  logic          tx_done,
  input  logic          append_req,
  input  logic          term_append,
  input  logic          flush_done,
  input  logic          host_wr,
  input  logic [SW-1:0] host_wdata,
  output logic [SW-1:0] status_o,
  output logic          append_err_o
);
  logic [NUM_DIR-1:0] first_vec, done_vec, busy_vec;
  buf_sel_e           next_vec [NUM_DIR];
  buf_sel_e           cur_vec  [NUM_DIR];
  logic [NUM_DIR-1:0] cur_bits;
  logic               app_act, app_rst, req_dropped, term_taken, flush_taken;
  logic               host_wr_seen;
  status_t            st;

  assign first_vec[DIR_RX] = rx_first_wr;
  assign first_vec[DIR_TX] = tx_first_rd;
  assign done_vec[DIR_RX]  = rx_done;
  assign done_vec[DIR_TX]  = tx_done;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    dbuf_dir_track u_dir (
      .clk(clk), .rst(rst),
      .first_acc(first_vec[d]), .done(done_vec[d]),
      .next_buf(next_vec[d]), .cur_buf(cur_vec[d]), .busy(busy_vec[d])
    );
    assign cur_bits[d] = cur_vec[d];
  end

  dbuf_append_ctl u_app (
    .clk(clk), .rst(rst),
    .append_req(append_req), .term_append(term_append), .flush_done(flush_done),
    .tx_busy(busy_vec[DIR_TX]), .tx_cur(cur_vec[DIR_TX]),
    .app_act(app_act), .app_rst(app_rst), .app_err(append_err_o),
    .req_dropped(req_dropped), .term_taken(term_taken), .flush_taken(flush_taken)
  );

  // write attempt that the status word must not absorb
  assign host_wr_seen = host_wr & (|host_wdata | 1'b1);

  always_comb begin
    st.rx_next = next_vec[DIR_RX];
    st.rx_busy = busy_vec[DIR_RX];
    st.tx_next = next_vec[DIR_TX];
    st.tx_busy = busy_vec[DIR_TX];
    st.tx_cur  = cur_vec[DIR_TX];
    st.app_act = app_act;
    st.app_rst = app_rst;
  end

  assign status_o = pack_status(st);
endmodule

// File: rtl/dbuf_status_checker.sv
module dbuf_status_checker
  import dbuf_status_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                rx_first_wr,
  input logic                rx_done,
  input logic                tx_first_rd,
  input logic                tx_done,
  input logic                append_req,
  input logic                term_append,
  input logic                flush_done,
  input logic                host_wr_seen,
  input logic                req_dropped,
  input logic [NUM_DIR-1:0]  cur_bits,
  input logic [STATUS_W-1:0] status_o,
  input logic                append_err_o
);
  logic quiet;
  assign quiet = ~(rx_first_wr | rx_done | tx_first_rd | tx_done |
                   append_req | term_append | flush_done);

  p_rx_flip_r2: assert property (@(posedge clk) disable iff (rst)
    rx_first_wr |=> status_o[B_RX_NEXT] != $past(status_o[B_RX_NEXT]));
  p_rx_cur_r2: assert property (@(posedge clk) disable iff (rst)
    rx_first_wr |=> cur_bits[DIR_RX] == $past(status_o[B_RX_NEXT]));
  p_tx_cur_r3: assert property (@(posedge clk) disable iff (rst)
    tx_first_rd |=> status_o[B_TX_CUR] == $past(status_o[B_TX_NEXT])
                    && cur_bits[DIR_TX] == status_o[B_TX_CUR]);
  p_busy_set_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_first_wr |=> status_o[B_RX_BUSY]) and (tx_first_rd |=> status_o[B_TX_BUSY]));
  p_busy_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_first_wr) |=> !status_o[B_RX_BUSY]);
  p_drop_r6: assert property (@(posedge clk) disable iff (rst)
    req_dropped |=> append_err_o && $stable(status_o[B_APP_ACT]));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    append_err_o |=> append_err_o);
  p_rst_needs_act_r7: assert property (@(posedge clk) disable iff (rst)
    status_o[B_APP_RST] |-> status_o[B_APP_ACT]);
  p_hostwr_r9: assert property (@(posedge clk) disable iff (rst)
    (host_wr_seen && quiet) |=> $stable(status_o));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    status_o[STATUS_W-1:B_APP_RST+1] == '0);
endmodule

bind dbuf_status_tracker dbuf_status_checker u_chk (
  .clk(clk), .rst(rst),
  .rx_first_wr(rx_first_wr), .rx_done(rx_done),
  .tx_first_rd(tx_first_rd), .tx_done(tx_done),
  .append_req(append_req), .term_append(term_append), .flush_done(flush_done),
  .host_wr_seen(host_wr_seen), .req_dropped(req_dropped),
  .cur_bits(cur_bits), .status_o(status_o), .append_err_o(append_err_o)
);

// File: tb/dbuf_status_tracker_bench.sv
module dbuf_status_tracker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_first_wr = 0, rx_done = 0, tx_first_rd = 0, tx_done = 0;
  logic append_req = 0, term_append = 0, flush_done = 0, host_wr = 0;
  logic [15:0] host_wdata = '0;
  logic [15:0] status_o;
  logic        append_err_o;
  int n_chk = 0, n_fail = 0;

  localparam int S_RXF = 1, S_RXD = 2, S_TXF = 4, S_TXD = 8;
  localparam int S_APP = 16, S_TERM = 32, S_FLUSH = 64, S_HWR = 128;

  always #5 clk = ~clk;

  dbuf_status_tracker u_dbuf_status_tracker (
    .clk(clk), .rst(rst), .rx_first_wr(rx_first_wr), .rx_done(rx_done),
    .tx_first_rd(tx_first_rd), .tx_done(tx_done), .append_req(append_req),
    .term_append(term_append), .flush_done(flush_done), .host_wr(host_wr),
    .host_wdata(host_wdata), .status_o(status_o), .append_err_o(append_err_o)
  );

  // expected word: rx next b0, rx busy b1, tx next b2, tx busy b3, tx cur b4, append b5, reset-append b6
  function automatic logic [15:0] mk(input int rxn, input int rxb, input int txn,
                                     input int txb, input int txc, input int ap,
                                     input int ra);
    return 16'((rxn) | (rxb << 1) | (txn << 2) | (txb << 3) | (txc << 4) |
               (ap << 5) | (ra << 6));
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    rx_first_wr = (s & S_RXF) != 0;  rx_done     = (s & S_RXD) != 0;
    tx_first_rd = (s & S_TXF) != 0;  tx_done     = (s & S_TXD) != 0;
    append_req  = (s & S_APP) != 0;  term_append = (s & S_TERM) != 0;
    flush_done  = (s & S_FLUSH) != 0; host_wr    = (s & S_HWR) != 0;
    host_wdata  = host_wr ? 16'hFFFF : 16'h0000;
    @(negedge clk);
    {rx_first_wr, rx_done, tx_first_rd, tx_done} = '0;
    {append_req, term_append, flush_done, host_wr} = '0;
    host_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    pulse(S_RXF | S_TXF | S_APP);
    do_reset();
    chk("R1 status", status_o, 16'h0000);
    chk("R1 err", {15'b0, append_err_o}, 16'h0000);
  endtask

  task automatic t_rx();
    do_reset();
    pulse(S_RXF);         chk("R2 first write A", status_o, mk(1,1,0,0,0,0,0));
    pulse(S_RXD);         chk("R4 rx done", status_o, mk(1,0,0,0,0,0,0));
    pulse(S_RXF);         chk("R2 first write B", status_o, mk(0,1,0,0,0,0,0));
    pulse(S_RXF | S_RXD); chk("R4 same-cycle", status_o, mk(1,1,0,0,0,0,0));
    pulse(S_RXD);         chk("R10 rx done next cycle", status_o, mk(1,0,0,0,0,0,0));
  endtask

  task automatic t_tx();
    do_reset();
    pulse(S_TXF); chk("R3 tx first read A", status_o, mk(0,0,1,1,0,0,0));
    pulse(S_TXD); chk("R4 tx done", status_o, mk(0,0,1,0,0,0,0));
    pulse(S_TXF); chk("R3 tx drains B", status_o, mk(0,0,0,1,1,0,0));
  endtask

  task automatic t_append_ok();
    do_reset();
    pulse(S_APP);   chk("R5 append set", status_o, mk(0,0,0,0,0,1,0));
    pulse(S_FLUSH); chk("R8 flush without term", status_o, mk(0,0,0,0,0,1,0));
    pulse(S_TERM);  chk("R7 term", status_o, mk(0,0,0,0,0,1,1));
    pulse(S_FLUSH); chk("R8 flush", status_o, mk(0,0,0,0,0,0,0));
    chk("R5 no err", {15'b0, append_err_o}, 16'h0000);
  endtask

  task automatic t_term_idle();
    do_reset();
    pulse(S_TERM);  chk("R7 term idle", status_o, 16'h0000);
    pulse(S_FLUSH); chk("R8 flush idle", status_o, 16'h0000);
  endtask

  task automatic t_append_blocked();
    do_reset();
    pulse(S_TXF);
    pulse(S_APP); chk("R6 dropped", status_o, mk(0,0,1,1,0,0,0));
    chk("R6 err set", {15'b0, append_err_o}, 16'h0001);
    pulse(S_TXD);
    pulse(S_APP); chk("R5 accepted idle", status_o, mk(0,0,1,0,0,1,0));
    chk("R6 err sticky", {15'b0, append_err_o}, 16'h0001);
    do_reset();
    chk("R1 err cleared", {15'b0, append_err_o}, 16'h0000);
  endtask

  task automatic t_append_busy_b();
    do_reset();
    pulse(S_TXF); pulse(S_TXD); pulse(S_TXF);
    pulse(S_APP); chk("R5 busy on B", status_o, mk(0,0,0,1,1,1,0));
    chk("R5 no err on B", {15'b0, append_err_o}, 16'h0000);
  endtask

  task automatic t_host_wr();
    do_reset();
    pulse(S_RXF);
    pulse(S_HWR); chk("R9 host write", status_o, mk(1,1,0,0,0,0,0));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset(); t_rx(); t_tx(); t_append_ok(); t_term_idle();
        t_append_blocked(); t_append_busy_b(); t_host_wr();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule